// File: doc/BRIEF.md
# Global-History Hashed Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the directions of recently resolved branches. It also keeps a table of two-bit saturating counters. On every cycle the word-aligned fetch address is XORed with the history to form a table index. The most significant bit of the addressed counter gives the direction guess. The index goes out with the guess so that the pipeline can carry it along with the branch.

When the branch resolves, the pipeline returns the carried index and the actual direction. The counter at that index moves one step toward the outcome, and the outcome is shifted into the history. Because the write uses the saved index, a history that has moved on since the prediction does not send the write to the wrong entry. Mixing the history into the index lets branches whose outcomes depend on other recent branches use separate counters.

Reset is asserted asynchronously and released on a clock edge inside the block. During reset every counter takes the weakly-taken value and the history clears to zero.

Top module: `gsp_predictor`

## Requirements
- R1: `pred_index` equals `fetch_pc_lo` XOR the current history register, bit for bit, combinationally.
- R2: Each cycle with `upd_valid` high, the history shifts left by one at the next edge, and bit 0 takes `upd_taken` (1 = taken, 0 = not taken). In cycles without `upd_valid` the history holds.
- R3: After reset, the history is all zeros and every counter holds 2'b10 (weakly taken), so every index predicts taken.
- R4: `pred_taken` is bit 1 of the counter at `pred_index`: codes 2'b11 and 2'b10 predict taken, codes 2'b01 and 2'b00 predict not taken.
- R5: An update with `upd_taken`=1 raises the counter at `upd_index` by one, and a counter at 2'b11 stays at 2'b11.
- R6: An update with `upd_taken`=0 lowers the counter at `upd_index` by one, and a counter at 2'b00 stays at 2'b00.
- R7: A counter in a strong state (2'b11 or 2'b00) flips its prediction only after two consecutive opposite outcomes. After one opposite outcome the prediction is unchanged.
- R8: An update writes only the entry named by `upd_index`. The counters of all other entries are unchanged.
- R9: When a prediction and an update fall in the same cycle, the prediction uses the counter and history as they were before that update. The new values are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc_lo | input | IDX_W | Low word-aligned fetch address bits (byte offset already dropped) |
| pred_taken | output | 1 | Direction guess for the current fetch address, 1 = taken |
| pred_index | output | IDX_W | Table index used for the guess, to be returned with the update |
| upd_valid | input | 1 | A conditional branch has resolved this cycle |
| upd_index | input | IDX_W | Index saved when that branch was predicted |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
A lookup and a resolve can fall in the same cycle, and they can hit the same counter. The bench provokes this by resolving a branch while fetching at the address that hashes to the entry being written. The expected guess and index are taken from the reference state before the update. The following cycle is then checked against the state after the update, for both the counter and the shifted history. The bench also runs a long stretch of random fetches and resolves, many of which overlap in this way, and scores every cycle against an independent reference model.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_WEAK_T    = 2'b10;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // Saturating step toward the resolved outcome.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) begin
      nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
    end else begin
      nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    end
    return nxt;
  endfunction

  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/gsp_rst_sync.sv
module gsp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/gsp_history.sv
module gsp_history #(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  // Next-state: youngest outcome enters at bit 0.
  always_comb begin
    hist_d = {hist_q[HIST_W-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else if (shift_en) begin
      hist_q <= hist_d;
    end
  end

  assign hist = hist_q;

  // R2: a resolved branch shifts its outcome in
  p_hist_shift_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    shift_en |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(shift_bit)});

  // R2: no resolve, no change
  p_hist_hold_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/gsp_index_hash.sv
module gsp_index_hash #(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] pc_bits,
  input  logic [IDX_W-1:0] hist,
  output logic [IDX_W-1:0] index
);

  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    assign index[b] = pc_bits[b] ^ hist[b];
  end

endmodule

// File: rtl/gsp_counter_table.sv
module gsp_counter_table
  import gsp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];
  ctr_t wr_cur;
  ctr_t wr_nxt;

  // Next-state for the single written entry.
  always_comb begin
    wr_cur = ctr_q[wr_idx];
    wr_nxt = ctr_step(wr_cur, wr_taken);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        ctr_q[i] <= CTR_WEAK_T;
      end
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_nxt;
    end
  end

  assign rd_taken = ctr_dir(ctr_q[rd_idx]);

  // R5: taken outcome climbs by one below the top
  p_inc_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_taken && wr_cur != CTR_STRONG_T)
      |=> ctr_q[$past(wr_idx)] == $past(wr_cur) + 2'd1);

  // R5: saturates at the top
  p_sat_hi_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_taken && wr_cur == CTR_STRONG_T)
      |=> ctr_q[$past(wr_idx)] == CTR_STRONG_T);

  // R6: not-taken outcome drops by one above the bottom
  p_dec_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !wr_taken && wr_cur != CTR_STRONG_NT)
      |=> ctr_q[$past(wr_idx)] == $past(wr_cur) - 2'd1);

  // R6: saturates at the bottom
  p_sat_lo_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !wr_taken && wr_cur == CTR_STRONG_NT)
      |=> ctr_q[$past(wr_idx)] == CTR_STRONG_NT);

  // R7: a strong counter keeps its direction after one opposite outcome
  p_strong_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && (wr_cur == CTR_STRONG_T || wr_cur == CTR_STRONG_NT))
      |=> ctr_dir(ctr_q[$past(wr_idx)]) == $past(wr_cur[1]));

endmodule

// File: rtl/gsp_predictor.sv
module gsp_predictor #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] fetch_pc_lo,
  output logic             pred_taken,
  output logic [IDX_W-1:0] pred_index,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_index,
  input  logic             upd_taken
);

  localparam int HIST_W = IDX_W;

  logic              rst_ni;
  logic [HIST_W-1:0] ghist;
  logic [IDX_W-1:0]  lookup_idx;

  gsp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  gsp_history #(.HIST_W(HIST_W)) u_history (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .shift_en  (upd_valid),
    .shift_bit (upd_taken),
    .hist      (ghist)
  );

  gsp_index_hash #(.IDX_W(IDX_W)) u_hash (
    .pc_bits (fetch_pc_lo),
    .hist    (ghist),
    .index   (lookup_idx)
  );

  gsp_counter_table #(.IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .rd_idx   (lookup_idx),
    .rd_taken (pred_taken),
    .wr_en    (upd_valid),
    .wr_idx   (upd_index),
    .wr_taken (upd_taken)
  );

  assign pred_index = lookup_idx;

  // R1: a stable fetch address with no resolve keeps the same index
  p_index_stable_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (!upd_valid ##1 $stable(fetch_pc_lo)) |-> $stable(pred_index));

endmodule

// File: tb/gsp_predictor_bench.sv
module gsp_predictor_bench;

  localparam int IDX_W = 10;
  localparam int DEPTH = 1 << IDX_W;

  typedef struct {
    logic             exp_t;
    logic [IDX_W-1:0] exp_i;
    string            req;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IDX_W-1:0] fetch_pc_lo = '0;
  logic             pred_taken;
  logic [IDX_W-1:0] pred_index;
  logic             upd_valid = 1'b0;
  logic [IDX_W-1:0] upd_index = '0;
  logic             upd_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  item_t exp_q[$];
  event  pushed;

  logic [1:0]       m_ctr [DEPTH];
  logic [IDX_W-1:0] m_hist;

  always #2.5 clk = ~clk;

  gsp_predictor #(.IDX_W(IDX_W)) u_gsp_predictor (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_pc_lo (fetch_pc_lo),
    .pred_taken  (pred_taken),
    .pred_index  (pred_index),
    .upd_valid   (upd_valid),
    .upd_index   (upd_index),
    .upd_taken   (upd_taken)
  );

  function automatic logic [1:0] ref_step(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    else   return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  // fetch address that lands on a given entry under the present reference history
  function automatic logic [IDX_W-1:0] pc_for(input logic [IDX_W-1:0] entry);
    return entry ^ m_hist;
  endfunction

  // Driver: one cycle of stimulus, expected outcome pushed to scoreboard.
  task automatic step(input logic [IDX_W-1:0] pc, input logic uv,
                      input logic [IDX_W-1:0] ui, input logic ut, input string req);
    item_t it;
    @(negedge clk);
    fetch_pc_lo = pc;
    upd_valid   = uv;
    upd_index   = ui;
    upd_taken   = ut;
    #1;
    it.exp_i = pc ^ m_hist;
    it.exp_t = m_ctr[it.exp_i][1];
    it.req   = req;
    exp_q.push_back(it);
    -> pushed;
    if (uv) begin
      m_ctr[ui] = ref_step(m_ctr[ui], ut);
      m_hist    = {m_hist[IDX_W-2:0], ut};
    end
  endtask

  task automatic look(input logic [IDX_W-1:0] pc, input string req);
    step(pc, 1'b0, '0, 1'b0, req);
  endtask

  // Monitor: compares design outputs with queued expectations.
  initial begin
    forever begin
      @(pushed);
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (pred_index !== it.exp_i) begin
          errors++;
          $display("FAIL %s: pred_index actual %h expected %h", it.req, pred_index, it.exp_i);
        end
        checks++;
        if (pred_taken !== it.exp_t) begin
          errors++;
          $display("FAIL %s: pred_taken actual %b expected %b", it.req, pred_taken, it.exp_t);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_ctr[i] = 2'b10;
    m_hist = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 / R1 / R4: reset state, all entries weakly taken, history zero
    look(10'h000, "R3");
    look(10'h3FF, "R3");
    look(10'h155, "R1");
    look(10'h2AA, "R4");

    // R2: history shift pattern observed through the index with a fixed address
    step(10'h000, 1'b1, 10'h3F0, 1'b1, "R2");
    look(10'h000, "R2");
    step(10'h000, 1'b1, 10'h3F1, 1'b0, "R2");
    step(10'h000, 1'b1, 10'h3F2, 1'b1, "R2");
    look(10'h000, "R2");
    look(10'h000, "R2");   // hold without resolves
    look(10'h0F0, "R1");

    // R5: climb entry 5 to strong taken and saturate
    step(pc_for(10'd5), 1'b1, 10'd5, 1'b1, "R5");
    look(pc_for(10'd5), "R5");
    step(pc_for(10'd5), 1'b1, 10'd5, 1'b1, "R5");
    look(pc_for(10'd5), "R5");
    // R7: one not-taken from strong keeps taken, the second flips it
    step(pc_for(10'd5), 1'b1, 10'd5, 1'b0, "R7");
    look(pc_for(10'd5), "R7");
    step(pc_for(10'd5), 1'b1, 10'd5, 1'b0, "R7");
    look(pc_for(10'd5), "R7");
    // R6: fall to strong not taken and saturate
    step(pc_for(10'd5), 1'b1, 10'd5, 1'b0, "R6");
    step(pc_for(10'd5), 1'b1, 10'd5, 1'b0, "R6");
    look(pc_for(10'd5), "R6");
    // R7: from strong not taken, one taken keeps not taken
    step(pc_for(10'd5), 1'b1, 10'd5, 1'b1, "R7");
    look(pc_for(10'd5), "R7");
    step(pc_for(10'd5), 1'b1, 10'd5, 1'b1, "R7");
    look(pc_for(10'd5), "R7");

    // R8: neighbours of the hammered entry untouched
    look(pc_for(10'd4), "R8");
    look(pc_for(10'd6), "R8");

    // R9: same-cycle lookup and resolve on one entry
    step(pc_for(10'd9), 1'b1, 10'd9, 1'b0, "R9");
    step(pc_for(10'd9), 1'b1, 10'd9, 1'b0, "R9");
    look(pc_for(10'd9), "R9");
    step(pc_for(10'd9), 1'b1, 10'd9, 1'b1, "R9");
    look(pc_for(10'd9), "R9");

    // Random mix, mostly on a small set of entries to force collisions
    for (int n = 0; n < 400; n++) begin
      logic [IDX_W-1:0] e;
      logic [IDX_W-1:0] ui;
      e  = IDX_W'($urandom_range(0, 7));
      ui = ($urandom_range(0, 1) == 1) ? e : IDX_W'($urandom_range(0, 7));
      step(pc_for(e), 1'($urandom_range(0, 1)), ui, 1'($urandom_range(0, 1)), "R9");
    end

    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule